// File: doc/BRIEF.md
# Hotplug Interrupt Locator Aggregator

This block collects hot-plug events from a set of slots, together with a command-completion flag, and condenses them into a locator word and one interrupt. Each slot owns a small event latch that hardware sets and software clears by writing ones, plus a mask byte that decides which latched events may raise the interrupt. A global control register holds four disable bits and two detected flags. The locator has one bit per slot plus bit 0 for command completion, so software learns which source wants service with a single read.

The computed interrupt level either drives a level pin directly, or, when message mode is on, produces a one-cycle notification pulse each time the level changes. A two-state recorder (`REC_LOW`, `REC_HIGH`) keeps the last sampled level: it moves `REC_LOW -> REC_HIGH` when the level rises and `REC_HIGH -> REC_LOW` when it falls, every cycle, whether or not message mode is on. Registers are reached through a simple write port and a combinational read port.

Top module: `hp_irq_locator`

## Requirements
- R1: An event input sets its latch bit on the next clock edge and the bit then holds. Latch bit order within a slot: 0 presence, 1 isolated fault, 2 button, 3 retention latch, 4 connected fault.
- R2: A write to slot s (address s+1) clears each latch bit whose matching `wr_data[4:0]` bit is 1 and leaves the other latch bits unchanged; the same write loads the mask from `wr_data[14:8]`.
- R3: When an event input and a write-1-to-clear hit the same latch bit in one cycle, the bit ends up set.
- R4: Locator bit s+1 is 1 exactly when slot s has some latch bit i (0..4) set with mask bit i clear. Mask bits 5 and 6 are stored and read back but never affect the locator.
- R5: Locator bit 0 is 1 exactly when the command-detected flag is set and the command-interrupt disable (control bit 2) is clear.
- R6: Control register (address 0): bits 3:0 are plain read/write disables; bit 16 (command detected) and bit 17 (arbiter detected) are set by `cmd_done` and `arb_detect` and cleared by writing 1, a set in the same cycle winning; all other bits read 0.
- R7: The level is 1 when the locator is nonzero and control bit 0 is clear. With `msg_en` low, `irq_pin` equals the level; with `msg_en` high, `irq_pin` is 0.
- R8: With `msg_en` high, `msg_pulse` is 1 for one cycle in the cycle after each clock edge at which the level changed, relative to the level recorded at the previous edge; with `msg_en` low it stays 0. The recorded level follows the level every cycle.
- R9: After reset every mask reads 0x7F, control bits 3:0 read 1, all latches and both flags read 0, the recorded level is low, and all outputs are 0.
- R10: Writes to addresses above the last slot change no state, and reads there return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_in | input | NSLOTS*5 | Event set strobes, slot s at bits 5s+4:5s |
| cmd_done | input | 1 | Sets the command-detected flag |
| arb_detect | input | 1 | Sets the arbiter-detected flag |
| msg_en | input | 1 | Selects message notification instead of level pin |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW | Write address: 0 control, s+1 slot s |
| wr_data | input | 32 | Write data |
| rd_addr | input | AW | Read address, same map |
| rd_data | output | 32 | Read data, combinational |
| locator | output | NSLOTS+1 | Interrupt locator |
| irq_pin | output | 1 | Level interrupt |
| msg_pulse | output | 1 | One-cycle notification |

## Verification
The bench aims at a set colliding with a clear on the same bit, which a clear-first design would lose so the slot would go silent; at mask bits 5 and 6, which a design treating the whole byte as a mask would let through or block wrongly; and at the locator offset, where a design without the +1 shift would report slot 0 as command completion. It also toggles message mode while the level moves, catching a recorder that only updates in message mode (a stale pulse on enable) or a pulse that lasts more than one cycle, and it writes to addresses past the last slot, where a loose decode would alias onto a real register.

// File: rtl/hp_irq_pkg.sv
package hp_irq_pkg;
    localparam int EVT_W      = 5;
    localparam int MASK_W     = 7;
    localparam int DIS_W      = 4;
    localparam int DATA_W     = 32;
    // field positions in the write/read words
    localparam int MASK_LSB   = 8;
    localparam int CMD_BIT    = 16;
    localparam int ARB_BIT    = 17;
    // control disable bit positions
    localparam int DIS_INT    = 0;
    localparam int DIS_CMDINT = 2;
    localparam logic [MASK_W-1:0] MASK_RST = '1;
    localparam logic [DIS_W-1:0]  DIS_RST  = '1;

    typedef enum logic {
        REC_LOW  = 1'b0,
        REC_HIGH = 1'b1
    } rec_state_e;
endpackage

// File: rtl/hp_slot_events.sv
module hp_slot_events
    import hp_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [EVT_W-1:0]  evt_in,
    input  logic              wr_hit,
    input  logic [EVT_W-1:0]  clr_bits,
    input  logic [MASK_W-1:0] mask_wr,
    output logic [EVT_W-1:0]  latch_o,
    output logic [MASK_W-1:0] mask_o,
    output logic              pend_o
);
    logic [EVT_W-1:0]  latch_q;
    logic [MASK_W-1:0] mask_q;
    logic [EVT_W-1:0]  latch_d;

    always_comb begin
        latch_d = latch_q;
        if (wr_hit) latch_d = latch_d & ~clr_bits;
        latch_d = latch_d | evt_in;   // set wins over clear
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            latch_q <= '0;
            mask_q  <= MASK_RST;
        end else begin
            latch_q <= latch_d;
            if (wr_hit) mask_q <= mask_wr;
        end
    end

    assign latch_o = latch_q;
    assign mask_o  = mask_q;
    assign pend_o  = |(latch_q & ~mask_q[EVT_W-1:0]);

    // R3
    evt_sets_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt_in) |=> ((latch_q & $past(evt_in)) == $past(evt_in)));
    // R2
    latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_hit && evt_in == '0) |=> $stable(latch_q));
endmodule

// File: rtl/hp_cmd_ctrl.sv
module hp_cmd_ctrl
    import hp_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_done,
    input  logic             arb_detect,
    input  logic             wr_hit,
    input  logic [DIS_W-1:0] dis_wr,
    input  logic             cmd_clr,
    input  logic             arb_clr,
    output logic [DIS_W-1:0] dis_o,
    output logic             cmd_o,
    output logic             arb_o
);
    logic [DIS_W-1:0] dis_q;
    logic             cmd_q;
    logic             arb_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dis_q <= DIS_RST;
            cmd_q <= 1'b0;
            arb_q <= 1'b0;
        end else begin
            if (wr_hit) dis_q <= dis_wr;
            cmd_q <= (cmd_q & ~(wr_hit & cmd_clr)) | cmd_done;
            arb_q <= (arb_q & ~(wr_hit & arb_clr)) | arb_detect;
        end
    end

    assign dis_o = dis_q;
    assign cmd_o = cmd_q;
    assign arb_o = arb_q;

    // R6
    cmd_flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_done |=> cmd_q);
    // R6
    arb_flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        arb_detect |=> arb_q);
endmodule

// File: rtl/hp_notify_fsm.sv
module hp_notify_fsm
    import hp_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic level,
    input  logic msg_en,
    output logic irq_pin,
    output logic msg_pulse
);
    rec_state_e state_q;
    rec_state_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            REC_LOW:  if (level)  state_d = REC_HIGH;
            REC_HIGH: if (!level) state_d = REC_LOW;
            default:  state_d = REC_LOW;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= REC_LOW;
        else        state_q <= state_d;
    end

    always_comb begin
        irq_pin   = 1'b0;
        msg_pulse = 1'b0;
        unique case (state_q)
            REC_LOW:  msg_pulse = msg_en & level;
            REC_HIGH: msg_pulse = msg_en & ~level;
            default:  msg_pulse = 1'b0;
        endcase
        if (!msg_en) irq_pin = level;
    end

    // R8
    pulse_needs_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        msg_pulse |-> msg_en);
    // R8
    pulse_on_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_en && level != $past(level)) |-> msg_pulse);
    // R7
    pin_quiet_in_msg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        msg_en |-> !irq_pin);
endmodule

// File: rtl/hp_irq_locator.sv
module hp_irq_locator
    import hp_irq_pkg::*;
#(
    parameter int NSLOTS = 4,
    localparam int AW    = $clog2(NSLOTS + 2),
    localparam int LOC_W = NSLOTS + 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NSLOTS*EVT_W-1:0] evt_in,
    input  logic                    cmd_done,
    input  logic                    arb_detect,
    input  logic                    msg_en,
    input  logic                    wr_en,
    input  logic [AW-1:0]           wr_addr,
    input  logic [DATA_W-1:0]       wr_data,
    input  logic [AW-1:0]           rd_addr,
    output logic [DATA_W-1:0]       rd_data,
    output logic [LOC_W-1:0]        locator,
    output logic                    irq_pin,
    output logic                    msg_pulse
);
    logic [EVT_W-1:0]  slot_latch [NSLOTS];
    logic [MASK_W-1:0] slot_mask  [NSLOTS];
    logic [NSLOTS-1:0] slot_pend;
    logic [DIS_W-1:0]  dis;
    logic              cmd_flag;
    logic              arb_flag;
    logic              level;

    for (genvar s = 0; s < NSLOTS; s++) begin : g_slot
        logic hit;
        assign hit = wr_en && (wr_addr == AW'(s + 1));
        hp_slot_events u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .evt_in   (evt_in[s*EVT_W +: EVT_W]),
            .wr_hit   (hit),
            .clr_bits (wr_data[EVT_W-1:0]),
            .mask_wr  (wr_data[MASK_LSB +: MASK_W]),
            .latch_o  (slot_latch[s]),
            .mask_o   (slot_mask[s]),
            .pend_o   (slot_pend[s])
        );
    end

    hp_cmd_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_done   (cmd_done),
        .arb_detect (arb_detect),
        .wr_hit     (wr_en && wr_addr == '0),
        .dis_wr     (wr_data[DIS_W-1:0]),
        .cmd_clr    (wr_data[CMD_BIT]),
        .arb_clr    (wr_data[ARB_BIT]),
        .dis_o      (dis),
        .cmd_o      (cmd_flag),
        .arb_o      (arb_flag)
    );

    assign locator = {slot_pend, cmd_flag & ~dis[DIS_CMDINT]};
    assign level   = (|locator) & ~dis[DIS_INT];

    hp_notify_fsm u_notify (
        .clk       (clk),
        .rst_n     (rst_n),
        .level     (level),
        .msg_en    (msg_en),
        .irq_pin   (irq_pin),
        .msg_pulse (msg_pulse)
    );

    always_comb begin
        rd_data = '0;
        if (rd_addr == '0) begin
            rd_data[DIS_W-1:0] = dis;
            rd_data[CMD_BIT]   = cmd_flag;
            rd_data[ARB_BIT]   = arb_flag;
        end
        for (int s = 0; s < NSLOTS; s++) begin
            if (rd_addr == AW'(s + 1)) begin
                rd_data[EVT_W-1:0]          = slot_latch[s];
                rd_data[MASK_LSB +: MASK_W] = slot_mask[s];
            end
        end
    end

    // R5
    cmd_loc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_flag && !dis[DIS_CMDINT]) |-> locator[0]);
    // R7
    level_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!msg_en && dis[DIS_INT]) |-> !irq_pin);
endmodule

// File: tb/hp_irq_locator_test.sv
module hp_irq_locator_test;
    localparam int NS = 4;
    localparam int AW = $clog2(NS + 2);

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NS*5-1:0] evt_in = '0;
    logic            cmd_done = 1'b0;
    logic            arb_detect = 1'b0;
    logic            msg_en = 1'b0;
    logic            wr_en = 1'b0;
    logic [AW-1:0]   wr_addr = '0;
    logic [31:0]     wr_data = '0;
    logic [AW-1:0]   rd_addr = '0;
    logic [31:0]     rd_data;
    logic [NS:0]     locator;
    logic            irq_pin;
    logic            msg_pulse;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    // reference model
    logic [4:0] m_latch [NS];
    logic [6:0] m_mask  [NS];
    logic [3:0] m_dis;
    logic       m_cmd, m_arb, m_prev;

    hp_irq_locator #(.NSLOTS(NS)) uut (
        .clk(clk), .rst_n(rst_n), .evt_in(evt_in), .cmd_done(cmd_done),
        .arb_detect(arb_detect), .msg_en(msg_en), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
        .rd_data(rd_data), .locator(locator), .irq_pin(irq_pin),
        .msg_pulse(msg_pulse)
    );

    always #4 clk = ~clk;

    function automatic logic [NS:0] f_loc();
        logic [NS:0] l;
        l[0] = m_cmd & ~m_dis[2];
        for (int s = 0; s < NS; s++) l[s+1] = |(m_latch[s] & ~m_mask[s][4:0]);
        return l;
    endfunction

    function automatic logic f_level();
        return (|f_loc()) & ~m_dis[0];
    endfunction

    function automatic logic [31:0] f_read(input int a);
        logic [31:0] r;
        r = '0;
        if (a == 0) begin
            r[3:0] = m_dis; r[16] = m_cmd; r[17] = m_arb;
        end else if (a <= NS) begin
            r[4:0] = m_latch[a-1]; r[14:8] = m_mask[a-1];
        end
        return r;
    endfunction

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h t=%0t", tag, got, exp, $time);
        end
    endtask

    task automatic model_reset();
        for (int s = 0; s < NS; s++) begin m_latch[s] = '0; m_mask[s] = 7'h7F; end
        m_dis = 4'hF; m_cmd = 0; m_arb = 0; m_prev = 0;
    endtask

    // Apply current inputs for one edge, update model, then check at negedge.
    task automatic step(input int rd);
        logic old_lvl;
        old_lvl = f_level();
        @(posedge clk);
        for (int s = 0; s < NS; s++) begin
            if (wr_en && int'(wr_addr) == s + 1) begin
                m_latch[s] = m_latch[s] & ~wr_data[4:0];
                m_mask[s]  = wr_data[14:8];
            end
            m_latch[s] = m_latch[s] | evt_in[s*5 +: 5];
        end
        if (wr_en && wr_addr == '0) begin
            m_dis = wr_data[3:0];
            if (wr_data[16]) m_cmd = 0;
            if (wr_data[17]) m_arb = 0;
        end
        m_cmd = m_cmd | cmd_done;
        m_arb = m_arb | arb_detect;
        m_prev = old_lvl;
        @(negedge clk);
        rd_addr = AW'(rd);
        #1;
        chk("R4 locator", 32'(locator), 32'(f_loc()));
        chk("R7 pin", 32'(irq_pin), 32'(~msg_en & f_level()));
        chk("R8 pulse", 32'(msg_pulse), 32'(msg_en & (f_level() != m_prev)));
        chk("R2 R6 readback", rd_data, f_read(rd));
        evt_in = '0; cmd_done = 0; arb_detect = 0; wr_en = 0; wr_data = '0;
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        wr_en = 1; wr_addr = AW'(a); wr_data = d;
    endtask

    initial begin
        #1500000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        model_reset();
        repeat (3) @(negedge clk);
        // R9 reset state, checked while in reset and after release
        for (int a = 0; a < (1 << AW); a++) begin
            rd_addr = AW'(a); #1;
            chk("R9 reset regs", rd_data, f_read(a));
        end
        chk("R9 reset outs", {locator, irq_pin, msg_pulse}, '0);
        rst_n = 1;
        step(0);

        // R1 presence event on slot 0, mask open bit0, enable ints
        wr(1, 32'h0000_7E00); step(1);          // R2 mask load: only bit0 unmasked
        wr(0, 32'h0000_0000); step(0);          // R6 clear disables
        evt_in[0] = 1; step(1);                 // R1 set, R8 level rises
        step(1);                                // R1 holds
        // R3 collision: clear and set same bit
        wr(1, 32'h0000_7E01); evt_in[0] = 1; step(1);
        // R2 clear with zero bits leaves latch
        wr(1, 32'h0000_7E00); step(1);
        wr(1, 32'h0000_7E01); step(1);          // R2 clear
        // R4 mask bits 5/6 have no effect: mask=0x60, event on button (bit2) slot 1
        wr(2, 32'h0000_6000); step(2);
        evt_in[5+2] = 1; step(2);
        wr(2, 32'h0000_1F00); step(2);          // R4 fully masked
        wr(2, 32'h0000_7F04); step(2);
        // R5 command detected
        msg_en = 1;
        cmd_done = 1; step(0);                  // R8 pulse on rise
        step(0);                                // R8 pulse ends
        wr(0, 32'h0000_0004); step(0);          // R5 cmd int disabled, R8 fall pulse
        wr(0, 32'h0001_0000); cmd_done = 1; step(0); // R6 set wins
        wr(0, 32'h0003_0000); step(0);          // R6 w1c both
        arb_detect = 1; step(0);
        // R10 out-of-range writes ignored
        wr(NS + 1, 32'hFFFF_FFFF); step(NS + 1);
        wr((1 << AW) - 1, 32'hFFFF_FFFF); step(0);
        msg_en = 0;

        // constrained random
        for (int i = 0; i < 4000; i++) begin
            for (int b = 0; b < NS*5; b++) evt_in[b] = ($urandom % 12) == 0;
            cmd_done   = ($urandom % 10) == 0;
            arb_detect = ($urandom % 10) == 0;
            if (($urandom % 20) == 0) msg_en = ~msg_en;
            if (($urandom % 3) == 0) begin
                logic [31:0] d;
                d = $urandom;
                if (($urandom % 2) == 0) d[0] = 1'b0;
                wr($urandom % (1 << AW), d);
            end
            step($urandom % (1 << AW));
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule